// File: doc/BRIEF.md
# Dual-Compare Programmable Interval Timer

A single timer channel with an up-counter and two maximum-count compare registers. Software programs it through a small register port: a control word, the live count, compare A and compare B. The control word picks where the count pulses come from: the system clock divided by a parameter (four by default), a pulse input driven by a neighbouring prescaler channel, or rising edges on the timer input pin, also divided by that factor. For internal counting, the pin either gates the count (it counts only while the pin is high) or restarts it (each rising edge clears the count).

In single mode the counter climbs to compare A and wraps to zero. In dual mode it alternates: it counts up to A, wraps, counts up to B, wraps, and returns to A. A status bit shows which compare register is active. Each wrap is a terminal count. It sets a sticky flag, gives a one-cycle pulse on `tc_pulse`, and in dual mode toggles `tog_out`, which another channel can use as a prescale source. In one-shot mode the terminal count also clears the enable bit, and the channel stops.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the control word, count, compare A and compare B all read 0, and `tc_pulse` and `tog_out` are 0.
- R2: Register addresses are 0 for control, 1 for count, 2 for compare A and 3 for compare B. The control bits are: bit0 continuous, bit1 dual, bit2 external, bit3 prescaler source, bit4 retrigger, bit5 max-count flag, bit6 active compare (read-only), bit7 enable. In single mode with compare A = a, each count pulse takes the counter from a to 0 and from any other value v to v+1. After n pulses starting from 0 the count is n mod (a+1).
- R3: In dual mode with compare values a and b, the count rises 0..a, wraps, rises 0..b, wraps, and the cycle repeats.
- R4: Control bit6 reads 0 while compare A is active and 1 while compare B is active. It reads 0 whenever dual mode is off.
- R5: The flag (bit5) is set on every terminal count and stays set. Writing the control word with bit5 = 0 clears it, and writing bit5 = 1 leaves it unchanged. If a clear and a set fall in the same cycle, the set wins.
- R6: With external = 0 and retrigger = 0, count pulses are ignored while the synchronized input pin is low.
- R7: With external = 0 and retrigger = 1, the pin level does not gate counting, and each rising edge on the pin clears the count to 0.
- R8: With external = 1, the count advances once for every four rising edges on the pin. The prescaler pulse input, retrigger and prescaler-source bits have no effect.
- R9: With external = 0 and prescaler source = 0, the count advances once every four clocks, measured from the clock edge that writes the control word.
- R10: With continuous = 0, a terminal count clears the enable bit, and the count then stays at 0 whatever pulses follow.
- R11: `tc_pulse` is high for exactly one cycle after each terminal count. `tog_out` toggles on each terminal count in dual mode and never changes in single mode.
- R12: A write to the count register loads the written value, and reading the count register then returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | W | Write data |
| rd_addr | input | 2 | Read register select |
| rd_data | output | W | Read data, combinational |
| tmr_in | input | 1 | Timer input pin, asynchronous |
| pre_pulse | input | 1 | Count pulse from a prescaler channel |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| tog_out | output | 1 | Toggles on terminal count in dual mode |

## Verification
The bench builds the timer with W = 8 and DIV = 4, so small compare values reach every wrap, alternation and flag case within a few dozen pulses. Because the prescaler pulse input is driven directly, each pulse is exactly one count step. The bench can therefore sweep compare A from 0 to 4 in single mode, and every pair of A and B values from 0 to 3 in dual mode, for up to 12 pulses each. The expected count, active-compare bit, flag and toggle parity come from modular arithmetic on the pulse count. Internal division is checked for 1 to 6 count steps.

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer #(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   rd_addr,
  output logic [W-1:0] rd_data,
  input  logic         tmr_in,
  input  logic         pre_pulse,
  output logic         tc_pulse,
  output logic         tog_out
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DIV - 1);

  logic         en, sel, flag, rtg, psrc, ext, dual, cont;
  logic [W-1:0] cnt, cmp_a, cmp_b;
  logic [DW-1:0] di, dx;
  logic         s1, s2, s3;

  wire wr_ctl = wr_en && wr_addr == 2'd0;
  wire wr_cnt = wr_en && wr_addr == 2'd1;
  wire rise   = s2 && !s3;
  wire retrig = !ext && rtg && rise;
  wire tick   = ext ? (rise && dx == DLAST) : (psrc ? pre_pulse : di == DLAST);
  wire adv    = en && tick && (ext || rtg || s2);
  wire [W-1:0] cmp_act = (dual && sel) ? cmp_b : cmp_a;
  wire term   = adv && !wr_cnt && !retrig && cnt == cmp_act;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {tmr_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      di <= '0;
      dx <= '0;
    end else if (wr_ctl) begin
      di <= '0;
      dx <= '0;
    end else begin
      di <= (di == DLAST) ? '0 : di + 1'b1;
      if (ext && rise) dx <= (dx == DLAST) ? '0 : dx + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {en, rtg, psrc, ext, dual, cont} <= '0;
    end else if (wr_ctl) begin
      en   <= wr_data[7];
      rtg  <= wr_data[4];
      psrc <= wr_data[3];
      ext  <= wr_data[2];
      dual <= wr_data[1];
      cont <= wr_data[0];
    end else if (term && !cont) begin
      en <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     flag <= 1'b0;
    else if (term)                  flag <= 1'b1;
    else if (wr_ctl && !wr_data[5]) flag <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    sel <= 1'b0;
    else if (!dual) sel <= 1'b0;
    else if (term)  sel <= !sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt   <= '0;
      cmp_a <= '0;
      cmp_b <= '0;
    end else begin
      if (wr_en && wr_addr == 2'd2) cmp_a <= wr_data;
      if (wr_en && wr_addr == 2'd3) cmp_b <= wr_data;
      if (wr_cnt)      cnt <= wr_data;
      else if (retrig) cnt <= '0;
      else if (term)   cnt <= '0;
      else if (adv)    cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tc_pulse <= 1'b0;
      tog_out  <= 1'b0;
    end else begin
      tc_pulse <= term;
      if (term && dual) tog_out <= !tog_out;
    end

  always_comb
    case (rd_addr)
      2'd0:    rd_data = W'({en, sel, flag, rtg, psrc, ext, dual, cont});
      2'd1:    rd_data = cnt;
      2'd2:    rd_data = cmp_a;
      default: rd_data = cmp_b;
    endcase

  a_r5_flag_follows_tc: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> flag);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_ctl && !wr_data[5]) |=> flag);
  a_r6_gate_holds: assert property (@(posedge clk) disable iff (!rst_n)
    en && !ext && !rtg && !s2 && !wr_en |=> $stable(cnt));
  a_r10_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    term && !cont && !wr_ctl |=> !en);
  a_r11_tog_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tog_out) |-> tc_pulse && $past(dual));
  a_r12_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt == $past(wr_data));
endmodule

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;
  localparam int W = 8;
  localparam logic [7:0] CONT = 8'h01, DUAL = 8'h02, EXT = 8'h04, PSRC = 8'h08,
                         RTG = 8'h10, FLG = 8'h20, EN = 8'h80;

  logic clk = 0, rst_n = 0, wr_en = 0, tmr_in = 0, pre_pulse = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [W-1:0] wr_data = 0, rd_data;
  logic tc_pulse, tog_out;
  int checks = 0, fails = 0;

  dual_cmp_timer #(.W(W), .DIV(4)) uut (.*);

  always #5 clk = !clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  task automatic pulse();
    @(negedge clk); pre_pulse = 1;
    @(negedge clk); pre_pulse = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int v, t0, t1, terms, p, r;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R1 ctl", v, 0);
    rd(1, v); chk("R1 cnt", v, 0);
    rd(2, v); chk("R1 cmpA", v, 0);
    rd(3, v); chk("R1 cmpB", v, 0);
    chk("R1 tc", tc_pulse, 0);
    chk("R1 tog", tog_out, 0);
    rst_n = 1;
    tmr_in = 1;
    settle(4);

    wr(1, 8'd37); rd(1, v); chk("R12 load", v, 37);

    for (int a = 0; a <= 4; a++)
      for (int n = 0; n <= 10; n++) begin
        wr(0, 0); wr(2, W'(a)); wr(1, 0); wr(0, EN | CONT | PSRC);
        t0 = tog_out;
        for (int k = 0; k < n; k++) pulse();
        rd(1, v); chk("R2 single count", v, n % (a + 1));
        rd(0, v); chk("R5 flag single", (v >> 5) & 1, (n >= a + 1) ? 1 : 0);
        chk("R4 sel single", (v >> 6) & 1, 0);
        chk("R11 tog single", tog_out, t0);
      end

    for (int a = 0; a <= 3; a++)
      for (int b = 0; b <= 3; b++)
        for (int n = 0; n <= 12; n++) begin
          wr(0, PSRC); wr(2, W'(a)); wr(3, W'(b)); wr(1, 0);
          wr(0, EN | CONT | PSRC | DUAL);
          t0 = tog_out;
          for (int k = 0; k < n; k++) pulse();
          p = a + b + 2; r = n % p; terms = 0;
          for (int k = 0; k < n; k++)
            if (k % p == a || k % p == p - 1) terms++;
          rd(1, v); chk("R3 dual count", v, (r <= a) ? r : r - a - 1);
          rd(0, v); chk("R4 sel dual", (v >> 6) & 1, (r <= a) ? 0 : 1);
          chk("R5 flag dual", (v >> 5) & 1, (n >= a + 1) ? 1 : 0);
          chk("R11 tog dual", tog_out, t0 ^ (terms & 1));
        end

    wr(0, 0); wr(2, 8'd2); wr(1, 0); wr(0, EN | CONT | PSRC);
    pulse(); chk("R11 tc low", tc_pulse, 0);
    pulse(); chk("R11 tc low", tc_pulse, 0);
    pulse(); chk("R11 tc high", tc_pulse, 1);
    settle(1); chk("R11 tc one cycle", tc_pulse, 0);

    wr(0, 0); wr(2, 8'd50); wr(1, 0); wr(0, EN | CONT | PSRC);
    tmr_in = 0; settle(4);
    for (int k = 0; k < 3; k++) pulse();
    rd(1, v); chk("R6 gated low", v, 0);
    tmr_in = 1; settle(4);
    for (int k = 0; k < 3; k++) pulse();
    rd(1, v); chk("R6 counts high", v, 3);

    wr(0, 0); wr(1, 0); tmr_in = 0; settle(4);
    wr(0, EN | CONT | PSRC | RTG);
    for (int k = 0; k < 3; k++) pulse();
    rd(1, v); chk("R7 no gating", v, 3);
    tmr_in = 1; settle(4);
    rd(1, v); chk("R7 retrigger clears", v, 0);
    pulse(); pulse();
    rd(1, v); chk("R7 counts after", v, 2);

    wr(0, 0); wr(1, 0); tmr_in = 0; settle(4);
    wr(0, EN | CONT | EXT | RTG);
    pre_pulse = 1;
    for (int k = 0; k < 9; k++) begin
      tmr_in = 1; settle(3); tmr_in = 0; settle(3);
    end
    pre_pulse = 0; settle(4);
    rd(1, v); chk("R8 external div4", v, 2);
    tmr_in = 1; settle(4);

    for (int k = 1; k <= 6; k++) begin
      wr(0, 0); wr(2, 8'd200); wr(1, 0); wr(0, EN | CONT);
      settle(4 * k);
      rd(1, v); chk("R9 internal div4", v, k);
    end

    wr(0, 0); wr(2, 8'd2); wr(1, 0); wr(0, EN | PSRC);
    for (int k = 0; k < 3; k++) pulse();
    rd(1, v); chk("R10 wrapped", v, 0);
    rd(0, v); chk("R10 enable cleared", (v >> 7) & 1, 0);
    chk("R5 flag set oneshot", (v >> 5) & 1, 1);
    pulse(); pulse();
    rd(1, v); chk("R10 stays stopped", v, 0);

    wr(0, PSRC | FLG); rd(0, v); chk("R5 write one keeps", (v >> 5) & 1, 1);
    wr(0, PSRC);       rd(0, v); chk("R5 write zero clears", (v >> 5) & 1, 0);

    wr(2, 8'd1); wr(1, 0); wr(0, EN | CONT | PSRC);
    pulse();
    rd(1, v); chk("R5 pre count", v, 1);
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = EN | CONT | PSRC; pre_pulse = 1;
    @(negedge clk); wr_en = 0; pre_pulse = 0;
    rd(0, v); chk("R5 set wins", (v >> 5) & 1, 1);
    rd(1, v); chk("R5 same cycle wrap", v, 0);

    t1 = checks;
    if (t1 < 12) fails++;
    finish_run();
  end
endmodule